// File: doc/BRIEF.md
# Pixel Stream Output Formatter

This block drives a parallel camera-style video bus from a store of 12-bit pixel samples. When the upstream frame store reports that a complete frame is held, the formatter frames it. It raises a frame flag and opens lines of programmable length, separated by programmable horizontal blanking. It closes the frame after a programmable trailing gap. Each cycle at most one pixel is taken from the source over a ready/valid handshake and placed on the output bus with a data-valid flag.

The output bus is ten bits wide. A format select chooses between a wide format and a narrow format. The wide format keeps the ten most significant bits of each sample. The narrow format keeps the eight most significant bits, right-aligned. Geometry, blanking and format are captured when a frame begins, so that software may rewrite them while a frame is in flight. If the source runs dry in the middle of a line, the line stays open and the output marks the idle cycles as carrying no pixel.

Top module: `pix_stream_fmt`

## Requirements
- R1: With `fmt_sel` = 0 (wide), each transferred pixel appears on `vid_data[9:0]` as `src_data[11:2]`.
- R2: With `fmt_sel` = 1 (narrow), each transferred pixel appears as `src_data[11:4]` on `vid_data[7:0]`, and `vid_data[9:8]` is zero.
- R3: `vid_dv` is high only while both `vid_fv` and `vid_lv` are high, and `vid_lv` is never high while `vid_fv` is low.
- R4: `vid_data` is all zero in every cycle where `vid_dv` is low.
- R5: During and right after reset all outputs are low. `vid_fv` stays low until `frame_ready` is seen high while the block is idle. A frame only begins after such a request.
- R6: Each line presents exactly the configured number of pixels per line, in the order the source delivers them, with `vid_lv` high without a break from the first pixel to the last.
- R7: Each frame holds exactly the configured number of lines.
- R8: `vid_fv` is high with `vid_lv` low for max(`cfg_lead`,1) cycles before the first line of a frame.
- R9: `vid_fv` stays high with `vid_lv` low for max(`cfg_trail`,1) cycles after the last line of a frame before it falls.
- R10: Between two lines of one frame, `vid_lv` is low for max(`cfg_hblank`,1) cycles. Pixel and line counts of 0 are treated as 1.
- R11: Geometry, blanking and `fmt_sel` are captured in the cycle a frame is requested. Changes made afterwards have no effect on that frame.
- R12: A cycle inside a line with `src_valid` low keeps `vid_lv` high, drives `vid_dv` low, and does not consume or skip a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_ready | input | 1 | Upstream store holds a complete frame |
| fmt_sel | input | 1 | 0 selects the 10-bit format, 1 the 8-bit format |
| cfg_pix_per_line | input | PPL_W | Pixels per line |
| cfg_lines | input | LPF_W | Lines per frame |
| cfg_lead | input | BLK_W | Frame-flag lead cycles before the first line |
| cfg_trail | input | BLK_W | Frame-flag trail cycles after the last line |
| cfg_hblank | input | BLK_W | Blanking cycles between lines |
| src_data | input | 12 | Pixel sample from the source |
| src_valid | input | 1 | Source offers a sample |
| src_ready | output | 1 | Block takes the sample this cycle |
| vid_data | output | 10 | Output pixel bus |
| vid_fv | output | 1 | Frame valid |
| vid_lv | output | 1 | Line valid |
| vid_dv | output | 1 | Data valid |

## Verification
Two things can land in the same cycle: a source stall and a line boundary. A stall may hit the first or last pixel of a line, or the cycle whose accept closes the frame. The bench drops `src_valid` on every third cycle and sweeps line lengths of one to four pixels, so the stall falls on every position in a line. It judges the result by the count of valid pixels per line, by the blanking length and by each pixel value against an arithmetic sample sequence. The other pairing is a configuration rewrite right after the frame request. It is provoked by writing unrelated geometry and the opposite format one cycle later, and judged by the framing and truncation of the whole frame.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

    localparam int SAMPLE_W = 12;
    localparam int BUS_W    = 10;
    localparam int NUM_BLK  = 3;

    // indices of the three blanking fields
    localparam int BLK_LEAD  = 0;
    localparam int BLK_HORZ  = 1;
    localparam int BLK_TRAIL = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_LINE  = 3'd2,
        ST_HBLK  = 3'd3,
        ST_TRAIL = 3'd4
    } seq_state_e;

    typedef enum logic {
        FMT_WIDE   = 1'b0,
        FMT_NARROW = 1'b1
    } out_fmt_e;

    typedef struct packed {
        logic             fv;
        logic             lv;
        logic             dv;
        logic [BUS_W-1:0] data;
    } vid_beat_t;

    // keep the top bits of a sample; narrow format is right-aligned
    function automatic logic [BUS_W-1:0] shape_sample(
        input logic [SAMPLE_W-1:0] s,
        input out_fmt_e            f
    );
        logic [BUS_W-1:0] r;
        if (f == FMT_NARROW)
            r = {2'b00, s[SAMPLE_W-1 -: 8]};
        else
            r = s[SAMPLE_W-1 -: BUS_W];
        return r;
    endfunction

endpackage

// File: rtl/pfmt_cfg_latch.sv
module pfmt_cfg_latch
    import pfmt_pkg::*;
#(
    parameter int PPL_W = 13,
    parameter int LPF_W = 12,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PPL_W-1:0] ppl_in,
    input  logic [LPF_W-1:0] lpf_in,
    input  logic [BLK_W-1:0] blk_in [NUM_BLK],
    input  logic             fmt_in,
    output logic [PPL_W-1:0] ppl_q,
    output logic [LPF_W-1:0] lpf_q,
    output logic [BLK_W-1:0] blk_q  [NUM_BLK],
    output out_fmt_e         fmt_q
);

    localparam logic [PPL_W-1:0] PPL_ONE = PPL_W'(1);
    localparam logic [LPF_W-1:0] LPF_ONE = LPF_W'(1);
    localparam logic [BLK_W-1:0] BLK_ONE = BLK_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ppl_q <= PPL_ONE;
            lpf_q <= LPF_ONE;
            fmt_q <= FMT_WIDE;
        end else if (load) begin
            ppl_q <= (ppl_in == '0) ? PPL_ONE : ppl_in;
            lpf_q <= (lpf_in == '0) ? LPF_ONE : lpf_in;
            fmt_q <= out_fmt_e'(fmt_in);
        end
    end

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst)
                blk_q[g] <= BLK_ONE;
            else if (load)
                blk_q[g] <= (blk_in[g] == '0) ? BLK_ONE : blk_in[g];
        end
    end

endmodule

// File: rtl/pfmt_seq.sv
module pfmt_seq
    import pfmt_pkg::*;
#(
    parameter int PPL_W = 13,
    parameter int LPF_W = 12,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_ready,
    input  logic             src_valid,
    input  logic [PPL_W-1:0] ppl,
    input  logic [LPF_W-1:0] lpf,
    input  logic [BLK_W-1:0] blk [NUM_BLK],
    output logic             load_cfg,
    output logic             in_frame,
    output logic             in_line,
    output logic             accept
);

    seq_state_e       state;
    logic [PPL_W-1:0] pix_cnt;
    logic [LPF_W-1:0] line_cnt;
    logic [BLK_W-1:0] blk_cnt;
    logic [BLK_W-1:0] blk_lim;
    logic             last_pix;
    logic             last_line;
    logic             blk_done;

    always_comb begin
        unique case (state)
            ST_LEAD: blk_lim = blk[BLK_LEAD];
            ST_HBLK: blk_lim = blk[BLK_HORZ];
            default: blk_lim = blk[BLK_TRAIL];
        endcase
    end

    always_comb begin
        load_cfg  = (state == ST_IDLE) && frame_ready;
        in_frame  = (state != ST_IDLE);
        in_line   = (state == ST_LINE);
        accept    = in_line && src_valid;
        last_pix  = (pix_cnt == ppl - PPL_W'(1));
        last_line = (line_cnt == lpf - LPF_W'(1));
        blk_done  = (blk_cnt == blk_lim - BLK_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pix_cnt  <= '0;
            line_cnt <= '0;
            blk_cnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frame_ready) begin
                        state    <= ST_LEAD;
                        pix_cnt  <= '0;
                        line_cnt <= '0;
                        blk_cnt  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (blk_done) begin
                        state   <= ST_LINE;
                        blk_cnt <= '0;
                    end else begin
                        blk_cnt <= blk_cnt + BLK_W'(1);
                    end
                end
                ST_LINE: begin
                    if (accept) begin
                        if (last_pix) begin
                            pix_cnt <= '0;
                            if (last_line) begin
                                state <= ST_TRAIL;
                            end else begin
                                state    <= ST_HBLK;
                                line_cnt <= line_cnt + LPF_W'(1);
                            end
                        end else begin
                            pix_cnt <= pix_cnt + PPL_W'(1);
                        end
                    end
                end
                ST_HBLK: begin
                    if (blk_done) begin
                        state   <= ST_LINE;
                        blk_cnt <= '0;
                    end else begin
                        blk_cnt <= blk_cnt + BLK_W'(1);
                    end
                end
                ST_TRAIL: begin
                    if (blk_done) begin
                        state   <= ST_IDLE;
                        blk_cnt <= '0;
                    end else begin
                        blk_cnt <= blk_cnt + BLK_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LINE && !src_valid) |=> (state == ST_LINE && $stable(pix_cnt)));

    // R10
    line_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LINE && accept && last_pix && !last_line) |=> (state == ST_HBLK));

endmodule

// File: rtl/pfmt_pack.sv
module pfmt_pack
    import pfmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_frame,
    input  logic                in_line,
    input  logic                accept,
    input  logic [SAMPLE_W-1:0] sample,
    input  out_fmt_e            fmt,
    output logic [BUS_W-1:0]    vid_data,
    output logic                vid_fv,
    output logic                vid_lv,
    output logic                vid_dv
);

    vid_beat_t beat_q;
    vid_beat_t beat_d;

    always_comb begin
        beat_d.fv   = in_frame;
        beat_d.lv   = in_line;
        beat_d.dv   = accept;
        beat_d.data = accept ? shape_sample(sample, fmt) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else
            beat_q <= beat_d;
    end

    assign vid_data = beat_q.data;
    assign vid_fv   = beat_q.fv;
    assign vid_lv   = beat_q.lv;
    assign vid_dv   = beat_q.dv;

    // R4
    blank_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !vid_dv |-> (vid_data == '0));

    // R2
    narrow_top_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fmt) == FMT_NARROW && vid_dv) |-> (vid_data[BUS_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/pix_stream_fmt.sv
module pix_stream_fmt
    import pfmt_pkg::*;
#(
    parameter int PPL_W = 13,
    parameter int LPF_W = 12,
    parameter int BLK_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_ready,
    input  logic                fmt_sel,
    input  logic [PPL_W-1:0]    cfg_pix_per_line,
    input  logic [LPF_W-1:0]    cfg_lines,
    input  logic [BLK_W-1:0]    cfg_lead,
    input  logic [BLK_W-1:0]    cfg_trail,
    input  logic [BLK_W-1:0]    cfg_hblank,
    input  logic [SAMPLE_W-1:0] src_data,
    input  logic                src_valid,
    output logic                src_ready,
    output logic [BUS_W-1:0]    vid_data,
    output logic                vid_fv,
    output logic                vid_lv,
    output logic                vid_dv
);

    logic [BLK_W-1:0] blk_raw [NUM_BLK];
    logic [BLK_W-1:0] blk_cur [NUM_BLK];
    logic [PPL_W-1:0] ppl_cur;
    logic [LPF_W-1:0] lpf_cur;
    out_fmt_e         fmt_cur;
    logic             load_cfg;
    logic             in_frame;
    logic             in_line;
    logic             accept;

    always_comb begin
        blk_raw[BLK_LEAD]  = cfg_lead;
        blk_raw[BLK_HORZ]  = cfg_hblank;
        blk_raw[BLK_TRAIL] = cfg_trail;
    end

    pfmt_cfg_latch #(
        .PPL_W(PPL_W), .LPF_W(LPF_W), .BLK_W(BLK_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load_cfg),
        .ppl_in (cfg_pix_per_line),
        .lpf_in (cfg_lines),
        .blk_in (blk_raw),
        .fmt_in (fmt_sel),
        .ppl_q  (ppl_cur),
        .lpf_q  (lpf_cur),
        .blk_q  (blk_cur),
        .fmt_q  (fmt_cur)
    );

    pfmt_seq #(
        .PPL_W(PPL_W), .LPF_W(LPF_W), .BLK_W(BLK_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_ready (frame_ready),
        .src_valid   (src_valid),
        .ppl         (ppl_cur),
        .lpf         (lpf_cur),
        .blk         (blk_cur),
        .load_cfg    (load_cfg),
        .in_frame    (in_frame),
        .in_line     (in_line),
        .accept      (accept)
    );

    pfmt_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .in_frame (in_frame),
        .in_line  (in_line),
        .accept   (accept),
        .sample   (src_data),
        .fmt      (fmt_cur),
        .vid_data (vid_data),
        .vid_fv   (vid_fv),
        .vid_lv   (vid_lv),
        .vid_dv   (vid_dv)
    );

    assign src_ready = in_line;

    // R3
    dv_framed_chk: assert property (@(posedge clk) disable iff (rst)
        vid_dv |-> (vid_fv && vid_lv));

    // R3
    lv_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        vid_lv |-> vid_fv);

    // R8
    lead_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vid_fv) |-> !vid_lv);

    // R9
    trail_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vid_fv) |-> !$past(vid_lv));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!vid_fv && !in_frame) |-> (!vid_lv && !vid_dv));

endmodule

// File: tb/pix_stream_fmt_bench.sv
module pix_stream_fmt_bench;

    localparam int PPL_W = 13;
    localparam int LPF_W = 12;
    localparam int BLK_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_ready = 1'b0;
    logic             fmt_sel = 1'b0;
    logic [PPL_W-1:0] cfg_pix_per_line = '0;
    logic [LPF_W-1:0] cfg_lines = '0;
    logic [BLK_W-1:0] cfg_lead = '0;
    logic [BLK_W-1:0] cfg_trail = '0;
    logic [BLK_W-1:0] cfg_hblank = '0;
    logic [11:0]      src_data = '0;
    logic             src_valid = 1'b0;
    logic             src_ready;
    logic [9:0]       vid_data;
    logic             vid_fv;
    logic             vid_lv;
    logic             vid_dv;

    pix_stream_fmt #(.PPL_W(PPL_W), .LPF_W(LPF_W), .BLK_W(BLK_W)) u_pix_stream_fmt (
        .clk(clk), .rst(rst), .frame_ready(frame_ready), .fmt_sel(fmt_sel),
        .cfg_pix_per_line(cfg_pix_per_line), .cfg_lines(cfg_lines),
        .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_hblank(cfg_hblank),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .vid_data(vid_data), .vid_fv(vid_fv), .vid_lv(vid_lv), .vid_dv(vid_dv)
    );

    always #5 clk = ~clk;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // expectations for the frame in flight
    int  exp_ppl, exp_lpf, exp_lead, exp_trail, exp_hb, exp_fmt;
    int  frame_no = 0;
    int  base = 0;
    int  acc = 0;
    bit  stall_en = 1'b0;
    bit  req_seen = 1'b0;
    bit  mon_on = 1'b0;
    int  frames_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sample_of(input int fr, input int idx);
        return (fr * 101 + idx * 37 + 5) % 4096;
    endfunction

    // source: one counter of accepted samples
    always @(posedge clk) begin
        if (!rst && src_valid && src_ready)
            acc <= acc + 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            src_valid = !(stall_en && (cyc % 3 == 1));
            src_data  = 12'(sample_of(frame_no, acc - base));
        end
    end

    // output monitor
    bit prev_fv = 1'b0, prev_lv = 1'b0, seen_line = 1'b0;
    int lead_n, gap_n, pix_line, lines_n, pix_idx;

    always @(negedge clk) begin
        if (mon_on) begin
            // R3
            chk(!vid_dv || (vid_fv && vid_lv), "R3 dv", int'(vid_dv), int'(vid_fv && vid_lv));
            chk(!vid_lv || vid_fv, "R3 lv", int'(vid_lv), int'(vid_fv));
            // R4
            if (!vid_dv) chk(vid_data == 10'd0, "R4", int'(vid_data), 0);
            if (vid_fv && !prev_fv) begin
                // R5: frame begins only on request
                chk(req_seen, "R5 start", 0, 1);
                req_seen  = 1'b0;
                lead_n    = 0; lines_n = 0; pix_idx = 0; gap_n = 0;
                seen_line = 1'b0;
            end
            if (vid_lv && !prev_lv) begin
                if (seen_line) chk(gap_n == exp_hb, "R10 hblank", gap_n, exp_hb);
                else           chk(lead_n == exp_lead, "R8 lead", lead_n, exp_lead);
                pix_line = 0;
            end
            if (vid_fv && !vid_lv && !seen_line) lead_n++;
            if (vid_dv) begin
                int v, e;
                v = sample_of(frame_no, pix_idx);
                e = (exp_fmt == 0) ? v / 4 : v / 16;
                if (exp_fmt == 0) chk(int'(vid_data) == e, "R1 wide", int'(vid_data), e);
                else              chk(int'(vid_data) == e, "R2 narrow", int'(vid_data), e);
                pix_idx++;
                pix_line++;
            end
            if (!vid_lv && prev_lv) begin
                chk(pix_line == exp_ppl, "R6 ppl R12", pix_line, exp_ppl);
                lines_n++;
                seen_line = 1'b1;
                gap_n = 0;
            end
            if (vid_fv && !vid_lv && seen_line) gap_n++;
            if (!vid_fv && prev_fv) begin
                chk(gap_n == exp_trail, "R9 trail", gap_n, exp_trail);
                chk(lines_n == exp_lpf, "R7 lines", lines_n, exp_lpf);
                frames_seen++;
            end
            prev_fv = vid_fv;
            prev_lv = vid_lv;
        end
    end

    task automatic run_frame(input int ppl, input int lpf, input int lead,
                             input int trail, input int hb, input int m, input bit st);
        int tgt;
        exp_ppl   = (ppl == 0) ? 1 : ppl;
        exp_lpf   = (lpf == 0) ? 1 : lpf;
        exp_lead  = (lead == 0) ? 1 : lead;
        exp_trail = (trail == 0) ? 1 : trail;
        exp_hb    = (hb == 0) ? 1 : hb;
        exp_fmt   = m;
        @(negedge clk);
        cfg_pix_per_line = PPL_W'(ppl);
        cfg_lines  = LPF_W'(lpf);
        cfg_lead   = BLK_W'(lead);
        cfg_trail  = BLK_W'(trail);
        cfg_hblank = BLK_W'(hb);
        fmt_sel    = m[0];
        stall_en   = st;
        frame_no++;
        base = acc;
        tgt = frames_seen + 1;
        frame_ready = 1'b1;
        req_seen = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
        // R11: rewrite everything once the frame is requested
        cfg_pix_per_line = PPL_W'(ppl + 3);
        cfg_lines  = LPF_W'(lpf + 2);
        cfg_lead   = BLK_W'(7);
        cfg_trail  = BLK_W'(6);
        cfg_hblank = BLK_W'(5);
        fmt_sel    = ~m[0];
        while (frames_seen < tgt) @(negedge clk);
        // R5: no new frame without a request
        repeat (4) begin
            @(negedge clk);
            chk(!vid_fv, "R5 idle", int'(vid_fv), 0);
        end
        chk(acc - base == exp_ppl * exp_lpf, "R12 consumed", acc - base, exp_ppl * exp_lpf);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state
        chk({vid_fv, vid_lv, vid_dv} == 3'b000, "R5 reset flags", int'({vid_fv, vid_lv, vid_dv}), 0);
        chk(vid_data == 10'd0, "R5 reset data", int'(vid_data), 0);
        chk(!src_ready, "R5 reset ready", int'(src_ready), 0);
        rst = 1'b0;
        mon_on = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(!vid_fv, "R5 no request", int'(vid_fv), 0);
        end
        for (int p = 1; p <= 4; p++)
            for (int l = 1; l <= 3; l++)
                for (int m = 0; m <= 1; m++)
                    for (int s = 0; s <= 1; s++)
                        run_frame(p, l, (p + m) % 3, (l + s) % 3, (p * l) % 3, m, s[0]);
        // R10: zero counts clamp to one
        run_frame(0, 0, 0, 0, 0, 1, 1'b1);
        run_frame(2, 2, 0, 0, 0, 0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", frames_seen, -1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule